// File: doc/BRIEF.md
# Serial Byte Receiver with Even-Parity Check

This block turns an asynchronous serial line into parallel bytes. Each frame is one low start bit, eight data bits sent least significant first, one parity bit and one high stop bit. When a frame ends with a valid stop bit, the block shows the byte on a parallel output. It raises a one-clock valid pulse and sets an error flag if the parity bit does not match the data. The byte and the flag keep their values until the next good frame.

The length of one bit, counted in system clocks, resets to the clock-frequency parameter divided by the baud-rate parameter. A write strobe with a 16-bit value can replace it at run time. The receiver copies the bit length it will use at the moment it detects a start edge, so a write during a frame affects only later frames. A receive enable controls whether a new start edge is accepted.

Internally, the line passes through a two-stage synchronizer before any edge detection. The start bit is checked again at half a bit. Every later bit is sampled once, one full bit after the previous sample.

Top module: `serial_rx_parity`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_byte_o` and `rx_perr_o` are all zero, and the bit length in use is CLK_HZ/BAUD clocks.
- R2: A frame on an idle-high line is decoded into `rx_byte_o`, with data bit 0 first on the line and bit 7 last. The frame is a low start bit, eight data bits, a parity bit and a high stop bit.
- R3: `rx_perr_o` is 1 when the parity bit differs from the XOR of the eight data bits, and 0 when they are equal (even parity).
- R4: The start bit is checked again half a bit after the falling edge. If the line is high at that point, the receiver returns to idle and gives no valid pulse.
- R5: If the stop bit is sampled low, the frame is discarded: no valid pulse is given, and `rx_byte_o` and `rx_perr_o` keep their previous values.
- R6: A falling edge is ignored while `rx_en_i` is low. A frame already started is still completed if `rx_en_i` drops during it.
- R7: `bit_len_wr_i` high for one clock loads `bit_len_i` as the new bit length. A frame uses the bit length copied when its start edge is detected. A write during a frame affects only later frames, and a write in the same clock as start detection applies to that frame.
- R8: `rx_valid_o` is high for exactly one clock per good frame. `rx_byte_o` and `rx_perr_o` change only in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_len_wr_i | input | 1 | Write strobe for the bit length |
| bit_len_i | input | 16 | New bit length in clocks |
| rxd_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable for new frames |
| rx_byte_o | output | 8 | Last received byte |
| rx_perr_o | output | 1 | Parity mismatch of the last received byte |
| rx_valid_o | output | 1 | One-clock pulse when a good frame completes |

## Verification
Two functions can fall in the same clock: a bit-length write and the detection of a start edge. The bench sets the line low just after a falling clock edge. It then counts the two synchronizer stages and raises the write strobe in exactly the clock where the synchronized edge is seen, and sends the whole frame at the newly written rate. A second scenario writes a different length in the middle of a frame, which must still decode at the old rate. In both scenarios, the scoreboard compares each byte and parity flag with the expected values, and checks that no valid pulse is missing or extra.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_PARITY = 3'd3,
    RX_STOP   = 3'd4
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // synchronizer chain, reset to idle-high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign line_s_o = chain_q[STAGES-1];
  assign fall_o   = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/srx_bitclk.sv
module srx_bitclk #(
  parameter int                  PER_W   = 16,
  parameter logic [PER_W-1:0]    DEF_PER = 16'd434
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [PER_W-1:0] wr_val_i,
  input  logic             start_i,
  input  logic             reload_i,
  output logic             tick_o
);
  logic [PER_W-1:0] period_q, frame_per_q, cnt_q;
  logic [PER_W-1:0] eff_per, half_per, half_load, cnt_d, frame_per_d, period_d;

  always_comb begin
    eff_per   = wr_i ? wr_val_i : period_q;   // same-clock write bypass
    half_per  = eff_per >> 1;
    half_load = (half_per == '0) ? '0 : half_per - 1'b1;
    period_d    = wr_i ? wr_val_i : period_q;
    frame_per_d = start_i ? eff_per : frame_per_q;
    if (start_i)
      cnt_d = half_load;
    else if (reload_i)
      cnt_d = (frame_per_q == '0) ? '0 : frame_per_q - 1'b1;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q    <= DEF_PER;
      frame_per_q <= DEF_PER;
      cnt_q       <= '0;
    end else begin
      period_q    <= period_d;
      frame_per_q <= frame_per_d;
      cnt_q       <= cnt_d;
    end
  end

  assign tick_o = (cnt_q == '0);

  AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> period_q == $past(wr_val_i)); // R7
  AST_FRAME_PER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(frame_per_q)); // R7
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              line_s_i,
  input  logic              fall_i,
  input  logic              tick_i,
  output logic              start_o,
  output logic              reload_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              perr_o,
  output logic              valid_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d, byte_q;
  logic              par_q, par_d, perr_q, valid_q, cap;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    par_d    = par_q;
    start_o  = 1'b0;
    reload_o = 1'b0;
    cap      = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (en_i && fall_i) begin
          state_d = RX_START;
          start_o = 1'b1;
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (!line_s_i) begin
            state_d  = RX_DATA;
            reload_o = 1'b1;
            idx_d    = '0;
          end else begin
            state_d = RX_IDLE;
          end
        end
      end
      RX_DATA: begin
        if (tick_i) begin
          sh_d     = {line_s_i, sh_q[DATA_W-1:1]};
          reload_o = 1'b1;
          if (idx_q == LAST_IDX) state_d = RX_PARITY;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      RX_PARITY: begin
        if (tick_i) begin
          par_d    = line_s_i;
          reload_o = 1'b1;
          state_d  = RX_STOP;
        end
      end
      RX_STOP: begin
        if (tick_i) begin
          state_d = RX_IDLE;
          cap     = line_s_i;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      byte_q  <= '0;
      perr_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      valid_q <= cap;
      if (cap) begin
        byte_q <= sh_q;
        perr_q <= (^sh_q) ^ par_q;
      end
    end
  end

  assign byte_o  = byte_q;
  assign perr_o  = perr_q;
  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(byte_q) && $stable(perr_q))); // R8
  AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && !en_i) |=> state_q == RX_IDLE); // R6
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick_i && line_s_i) |=> (state_q == RX_IDLE && !valid_q)); // R4
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_STOP && tick_i && !line_s_i) |=> !valid_q); // R5
endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 115_200,
  parameter int PER_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_len_wr_i,
  input  logic [PER_W-1:0]  bit_len_i,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_perr_o,
  output logic              rx_valid_o
);
  localparam int               DEF_PER   = CLK_HZ / BAUD;
  localparam logic [PER_W-1:0] DEF_PER_V = PER_W'(DEF_PER);

  logic line_s, fall, tick, start, reload;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (rxd_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  srx_bitclk #(.PER_W(PER_W), .DEF_PER(DEF_PER_V)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bit_len_wr_i),
    .wr_val_i (bit_len_i),
    .start_i  (start),
    .reload_i (reload),
    .tick_o   (tick)
  );

  srx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (rx_en_i),
    .line_s_i (line_s),
    .fall_i   (fall),
    .tick_i   (tick),
    .start_o  (start),
    .reload_o (reload),
    .byte_o   (rx_byte_o),
    .perr_o   (rx_perr_o),
    .valid_o  (rx_valid_o)
  );
endmodule

// File: tb/serial_rx_parity_bench.sv
`timescale 1ns/1ps
module serial_rx_parity_bench;
  localparam int CLK_HZ = 3_200_000;
  localparam int BAUD   = 200_000;
  localparam int DEFP   = CLK_HZ / BAUD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [15:0] wr_val;
  logic        rxd;
  logic        en;
  logic [7:0]  byte_o;
  logic        perr;
  logic        valid;

  int checks = 0;
  int fails  = 0;
  logic [8:0] exp_q[$];
  string      cur_req = "R2";
  logic       prev_valid = 1'b0;
  bit         done = 1'b0;

  serial_rx_parity #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_serial_rx_parity (
    .clk(clk), .rst_n(rst_n), .bit_len_wr_i(wr), .bit_len_i(wr_val),
    .rxd_i(rxd), .rx_en_i(en), .rx_byte_o(byte_o), .rx_perr_o(perr),
    .rx_valid_o(valid)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each valid pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (valid && prev_valid)
        chk(1'b0, "R8", "valid wider than one clock", 32'd2, 32'd1);
      if (valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected valid", {23'd0, perr, byte_o}, 32'd0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({perr, byte_o} == e, cur_req, "byte/parity",
              {23'd0, perr, byte_o}, {23'd0, e});
        end
      end
      prev_valid <= valid;
    end
  end

  // driver: wr_mode 0 none, 1 write in start-detect clock, 2 write mid-frame
  task automatic send(input logic [7:0] d, input int per, input bit bad_par,
                      input bit stop_low, input bit expect_ok, input bit drop_en,
                      input int wr_mode, input logic [15:0] wv, input string req);
    cur_req = req;
    if (expect_ok) exp_q.push_back({bad_par, d});
    @(negedge clk); rxd = 1'b0;
    if (wr_mode == 1) begin
      @(negedge clk); @(negedge clk);
      wr = 1'b1; wr_val = wv;
      @(negedge clk); wr = 1'b0;
      repeat (per - 3) @(negedge clk);
    end else begin
      repeat (per) @(negedge clk);
    end
    if (drop_en) en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      if (wr_mode == 2 && i == 3) begin
        @(negedge clk); wr = 1'b1; wr_val = wv;
        @(negedge clk); wr = 1'b0;
        repeat (per - 2) @(negedge clk);
      end else begin
        repeat (per) @(negedge clk);
      end
    end
    rxd = (^d) ^ bad_par;
    repeat (per) @(negedge clk);
    rxd = ~stop_low;
    repeat (per) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * per) @(negedge clk);
    if (drop_en) en = 1'b1;
    chk(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "WATCHDOG", "run timed out", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; wr_val = '0; rxd = 1'b1; en = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
    chk(byte_o == 8'h00, "R1", "byte after reset", byte_o, 0);
    chk(perr == 1'b0, "R1", "perr after reset", perr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);

    // R1 default bit length, R2 framing and bit order
    send(8'hA5, DEFP, 0, 0, 1, 0, 0, 16'd0, "R1");
    send(8'h3C, DEFP, 0, 0, 1, 0, 0, 16'd0, "R2");
    send(8'h00, DEFP, 0, 0, 1, 0, 0, 16'd0, "R2");
    send(8'hFF, DEFP, 0, 0, 1, 0, 0, 16'd0, "R2");
    send(8'h01, DEFP, 0, 0, 1, 0, 0, 16'd0, "R2");

    // R3 parity error flagged, then cleared on a good frame
    send(8'h5A, DEFP, 1, 0, 1, 0, 0, 16'd0, "R3");
    send(8'h80, DEFP, 1, 0, 1, 0, 0, 16'd0, "R3");
    send(8'h96, DEFP, 0, 0, 1, 0, 0, 16'd0, "R3");

    // R4 false start: low for less than half a bit
    cur_req = "R4";
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (4 * DEFP) @(negedge clk);
    chk(byte_o == 8'h96 && perr == 1'b0, "R4", "outputs after false start",
        {23'd0, perr, byte_o}, 32'h096);
    send(8'h81, DEFP, 0, 0, 1, 0, 0, 16'd0, "R4");

    // R5 stop bit low discards frame, outputs hold
    send(8'h42, DEFP, 1, 1, 0, 0, 0, 16'd0, "R5");
    chk(byte_o == 8'h81 && perr == 1'b0, "R5", "outputs after framing error",
        {23'd0, perr, byte_o}, 32'h081);
    send(8'h24, DEFP, 0, 0, 1, 0, 0, 16'd0, "R5");

    // R6 enable low ignores start; drop mid-frame still completes
    en = 1'b0;
    send(8'h77, DEFP, 0, 0, 0, 0, 0, 16'd0, "R6");
    chk(byte_o == 8'h24, "R6", "byte held while disabled", byte_o, 32'h24);
    en = 1'b1;
    repeat (2) @(negedge clk);
    send(8'hE1, DEFP, 0, 0, 1, 1, 0, 16'd0, "R6");

    // R7 run-time bit length: idle write, mid-frame write, same-clock write
    @(negedge clk); wr = 1'b1; wr_val = 16'd12;
    @(negedge clk); wr = 1'b0;
    send(8'hC3, 12, 0, 0, 1, 0, 0, 16'd0, "R7");
    send(8'h6D, 12, 0, 0, 1, 0, 2, 16'd20, "R7");
    send(8'h9E, 20, 1, 0, 1, 0, 0, 16'd0, "R7");
    send(8'h3B, 10, 0, 0, 1, 0, 1, 16'd10, "R7");
    send(8'hD4, 10, 0, 0, 1, 0, 0, 16'd0, "R7");

    // R8 outputs hold between frames
    repeat (50) @(negedge clk);
    chk(byte_o == 8'hD4 && perr == 1'b0 && valid == 1'b0, "R8",
        "outputs hold when idle", {22'd0, valid, perr, byte_o}, 32'h0D4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule